// File: doc/BRIEF.md
# Data-Dependent Latency Sequential Multiplier

This block multiplies two 16-bit words over many clocks and returns a 32-bit product. A mode input chooses between unsigned and two's-complement arithmetic. The time the block stays busy depends on the multiplier operand. This lets a cycle-accurate processor model charge exactly the clocks that an instruction-level timing rule assigns to a multiply.

The multiplier operand is recoded into one digit per bit position. In unsigned mode each one bit is a digit of +1. In signed mode each digit is the radix-2 Booth digit, formed from the bit and its lower neighbour, with a zero placed below the lowest bit. The block walks the digits from least to most significant. A zero digit costs one clock. A nonzero digit adds or subtracts the shifted multiplicand and then holds for two further clocks. A fixed tail follows the scan, which makes the total busy time 38 + 2n clocks, where n is the number of nonzero digits.

The operands and the mode are captured when a start is accepted. Start is accepted only while the block is idle. The product register changes only at completion, and a one-clock done pulse marks that update.

Top module: `vlat_mul`

## Requirements
- R1: While reset is held and in the first cycle after it is released, busy is 0, done is 0 and product is 0.
- R2: With signed_mode = 0, the product is the unsigned 32-bit product of the two zero-extended 16-bit operands.
- R3: With signed_mode = 1, the product is the 32-bit two's-complement product of the two operands, each taken as a signed 16-bit value.
- R4: With signed_mode = 0, busy is 1 for exactly 38 + 2n consecutive cycles starting the cycle after the accepting clock edge. Here n is the number of one bits in the multiplier operand.
- R5: With signed_mode = 1, the busy time is 38 + 2n cycles, where n is the number of positions i (0 to 15) at which bit i differs from bit i-1, taking bit -1 as 0. A multiplier of 0x5555 gives 70 cycles and 0xFFFF gives 40 cycles.
- R6: Done is 1 for exactly one cycle, the first cycle after busy falls, with busy at 0 in that cycle. Product holds the new result in that cycle.
- R7: A start raised while busy is 1 is ignored. The running operation keeps its operands, its mode, its latency and its result.
- R8: Product changes only in a done cycle. Between done pulses it holds its value.
- R9: A multiplier operand of zero gives a product of 0 and a busy time of 38 cycles in both modes.
- R10: A start raised in the done cycle is accepted, so operations can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiply; accepted on a clock edge while idle |
| signed_mode | input | 1 | 1 selects two's-complement, 0 selects unsigned |
| mcand | input | 16 | Multiplicand operand |
| mplier | input | 16 | Multiplier (source) operand; sets the latency |
| product | output | 32 | Result register, updated at completion |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while an operation runs |

## Verification
On every cycle, the assertions check four behaviours: the busy-cycle count equals the latency rule for the captured operand, done lasts one cycle and follows the fall of busy, the captured operands stay frozen while busy, and the product moves only in a done cycle. Only the bench scenarios can show that the product values are arithmetically right in both modes, across single-bit, alternating-bit, all-ones, zero and pseudo-random operands. The same holds for the two timing cases: a start strobe during an operation leaves the outcome unchanged, and a start in the done cycle begins the next operation at once.

// File: rtl/vlat_mul_pkg.sv
package vlat_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_TAIL = 2'd2
    } mul_state_e;

endpackage

// File: rtl/vlat_mul_digit.sv
// Recodes the multiplier into one digit per bit position and selects the
// digit at the current scan index.
module vlat_mul_digit #(
    parameter int W = 16
) (
    input  logic [W-1:0]         mplier,
    input  logic [$clog2(W)-1:0] idx,
    input  logic                 sgn,
    output logic                 nz,
    output logic                 neg
);
    logic [W-1:0] nz_vec;
    logic [W-1:0] neg_vec;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_dig
            if (gi == 0) begin : g_lsb
                // the bit below the lowest position reads as zero
                assign nz_vec[gi]  = mplier[gi];
                assign neg_vec[gi] = sgn & mplier[gi];
            end else begin : g_mid
                assign nz_vec[gi]  = sgn ? (mplier[gi] ^ mplier[gi-1]) : mplier[gi];
                assign neg_vec[gi] = sgn & mplier[gi] & ~mplier[gi-1];
            end
        end
    endgenerate

    always_comb begin
        nz  = nz_vec[idx];
        neg = neg_vec[idx];
    end

endmodule

// File: rtl/vlat_mul_acc.sv
// Partial-product accumulator: adds or subtracts the extended multiplicand
// shifted by the scan index.
module vlat_mul_acc #(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 add_en,
    input  logic                 neg,
    input  logic                 sgn,
    input  logic [W-1:0]         mcand,
    input  logic [$clog2(W)-1:0] idx,
    output logic [2*W-1:0]       acc
);
    localparam int PW = 2 * W;

    logic [PW-1:0] acc_q, acc_d;
    logic [PW-1:0] ext;
    logic [PW-1:0] addend;

    always_comb begin
        ext    = {{W{sgn & mcand[W-1]}}, mcand};
        addend = ext << idx;
        acc_d  = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (add_en) begin
            acc_d = neg ? (acc_q - addend) : (acc_q + addend);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign acc = acc_q;

endmodule

// File: rtl/vlat_mul.sv
module vlat_mul #(
    parameter int W    = 16,
    parameter int BASE = 38,
    parameter int NZ   = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           signed_mode,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] product,
    output logic           done,
    output logic           busy
);
    import vlat_mul_pkg::*;

    localparam int IDX_W  = $clog2(W);
    localparam int TAIL   = BASE - W;
    localparam int TAIL_W = $clog2(TAIL + 1);
    localparam int HOLD_W = $clog2(NZ + 1);
    localparam int LAT_W  = $clog2(BASE + NZ * W + 2);

    typedef struct packed {
        mul_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic [HOLD_W-1:0]  hold;
        logic [TAIL_W-1:0]  tail;
        logic [W-1:0]       mcand;
        logic [W-1:0]       mplier;
        logic               sgn;
        logic [2*W-1:0]     result;
        logic               done;
    } ctl_t;

    ctl_t c_q, c_d;

    logic           dig_nz, dig_neg;
    logic           acc_clear, acc_add;
    logic [2*W-1:0] acc_val;
    logic           last_idx;

    vlat_mul_digit #(.W(W)) u_digit (
        .mplier (c_q.mplier),
        .idx    (c_q.idx),
        .sgn    (c_q.sgn),
        .nz     (dig_nz),
        .neg    (dig_neg)
    );

    vlat_mul_acc #(.W(W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (acc_clear),
        .add_en (acc_add),
        .neg    (dig_neg),
        .sgn    (c_q.sgn),
        .mcand  (c_q.mcand),
        .idx    (c_q.idx),
        .acc    (acc_val)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        acc_clear = 1'b0;
        acc_add   = 1'b0;
        last_idx  = (c_q.idx == IDX_W'(W - 1));
        case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st     = ST_SCAN;
                    c_d.idx    = '0;
                    c_d.hold   = '0;
                    c_d.mcand  = mcand;
                    c_d.mplier = mplier;
                    c_d.sgn    = signed_mode;
                    acc_clear  = 1'b1;
                end
            end
            ST_SCAN: begin
                if (c_q.hold != '0) begin
                    // settle clocks charged to a nonzero digit
                    c_d.hold = c_q.hold - 1'b1;
                    if (c_q.hold == HOLD_W'(1)) begin
                        if (last_idx) begin
                            c_d.st   = ST_TAIL;
                            c_d.tail = TAIL_W'(TAIL - 1);
                        end else begin
                            c_d.idx = c_q.idx + 1'b1;
                        end
                    end
                end else if (dig_nz) begin
                    acc_add  = 1'b1;
                    c_d.hold = HOLD_W'(NZ);
                end else begin
                    if (last_idx) begin
                        c_d.st   = ST_TAIL;
                        c_d.tail = TAIL_W'(TAIL - 1);
                    end else begin
                        c_d.idx = c_q.idx + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (c_q.tail == '0) begin
                    c_d.st     = ST_IDLE;
                    c_d.result = acc_val;
                    c_d.done   = 1'b1;
                end else begin
                    c_d.tail = c_q.tail - 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign product = c_q.result;
    assign done    = c_q.done;
    assign busy    = (c_q.st != ST_IDLE);

    // ---------------- assertions ----------------
    // independent busy-cycle counter used only by the latency check
    logic [LAT_W-1:0] lat_cnt_q;
    int               exp_lat;

    always_ff @(posedge clk) begin
        if (rst)                     lat_cnt_q <= '0;
        else if (!busy && start)     lat_cnt_q <= '0;
        else if (busy)               lat_cnt_q <= lat_cnt_q + 1'b1;
    end

    always_comb begin
        exp_lat = BASE + NZ * $countones(c_q.sgn ? (c_q.mplier ^ {c_q.mplier[W-2:0], 1'b0})
                                                 : c_q.mplier);
    end

    // R4 and R5: busy lasted exactly the charged number of cycles
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(lat_cnt_q) == exp_lat));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_done_follows_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r7_operands_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(c_q.mcand) && $stable(c_q.mplier) && $stable(c_q.sgn)));

    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(product) |-> done);

endmodule

// File: tb/vlat_mul_bench.sv
module vlat_mul_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [15:0] mcand = '0;
    logic [15:0] mplier = '0;
    logic [31:0] product;
    logic        done;
    logic        busy;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [31:0] last_prod = '0;
    logic [31:0] rng = 32'h2545_F491;

    vlat_mul u_vlat_mul (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .signed_mode (signed_mode),
        .mcand       (mcand),
        .mplier      (mplier),
        .product     (product),
        .done        (done),
        .busy        (busy)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic int exp_latency(input logic [15:0] b, input bit s);
        int n = 0;
        for (int i = 0; i < 16; i++) begin
            if (s) begin
                if (b[i] != ((i == 0) ? 1'b0 : b[i-1])) n++;
            end else if (b[i]) n++;
        end
        return 38 + 2 * n;
    endfunction

    function automatic logic [31:0] exp_product(input logic [15:0] a,
                                                input logic [15:0] b, input bit s);
        logic [31:0] ea, eb;
        ea = s ? {{16{a[15]}}, a} : {16'h0, a};
        eb = s ? {{16{b[15]}}, b} : {16'h0, b};
        return ea * eb;
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Called at a negedge; returns at the negedge where done is seen.
    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit s,
                          input bit inject, input string tag);
        int          cyc = 0;
        bit          seen = 0;
        int          el;
        logic [31:0] ep;
        el = exp_latency(b, s);
        ep = exp_product(a, b, s);
        mcand = a; mplier = b; signed_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 400 && !seen; k++) begin
            if (busy) cyc++;
            if (inject && busy && cyc == 5) begin
                start = 1'b1; mcand = ~a; mplier = b ^ 16'h00FF; signed_mode = ~s;
            end else begin
                start = 1'b0;
            end
            if (done) seen = 1;
            else @(negedge clk);
        end
        start = 1'b0;
        check(seen, {tag, " R6 done pulse seen"}, 32'(seen), 32'd1);
        check(cyc == el, {tag, s ? " R5 signed latency" : " R4 unsigned latency"},
              32'(cyc), 32'(el));
        check(product == ep, {tag, s ? " R3 signed product" : " R2 unsigned product"},
              product, ep);
        check(!busy, {tag, " R6 busy low in done cycle"}, 32'(busy), 32'd0);
        last_prod = product;
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!done, "R6 done lasts one cycle", 32'(done), 32'd0);
            check(product == last_prod, "R8 product holds", product, last_prod);
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                fails++;
                tests++;
                $display("FAIL watchdog: actual %0d expected below 190000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin : main
        logic [15:0] pats [4];
        pats[0] = 16'h7FFF; pats[1] = 16'h8000; pats[2] = 16'hFFFF; pats[3] = 16'h1234;

        repeat (3) @(negedge clk);
        check(!busy && !done && product == 0, "R1 state in reset",
              {product[29:0], busy, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && product == 0, "R1 state after reset",
              {product[29:0], busy, done}, 32'd0);

        // R9: zero source in both modes
        run_op(16'hBEEF, 16'h0000, 1'b0, 1'b0, "R9");
        idle_gap(2);
        run_op(16'h8001, 16'h0000, 1'b1, 1'b0, "R9");
        idle_gap(2);

        // Named worst and best cases
        run_op(16'hFFFF, 16'h5555, 1'b1, 1'b0, "R5 0x5555");
        idle_gap(1);
        run_op(16'h8000, 16'hFFFF, 1'b1, 1'b0, "R5 0xFFFF");
        idle_gap(1);
        run_op(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, "R4 0xFFFF");
        idle_gap(1);
        run_op(16'h8000, 16'h8000, 1'b1, 1'b0, "R3 min*min");
        idle_gap(1);
        run_op(16'h7FFF, 16'hAAAA, 1'b1, 1'b0, "R5 0xAAAA");
        idle_gap(1);

        // Single-bit multiplier sweep across positions and multiplicands
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 16; p++) begin
                for (int q = 0; q < 4; q++) begin
                    run_op(pats[q], 16'(1 << p), m[0], 1'b0, "sweep");
                    idle_gap(1);
                end
            end
        end

        // R7: start strobes during an operation are ignored
        run_op(16'h1357, 16'h2468, 1'b0, 1'b1, "R7");
        idle_gap(3);
        run_op(16'hF00D, 16'h9C3A, 1'b1, 1'b1, "R7");
        idle_gap(3);

        // R10: back-to-back operations
        run_op(16'h00FF, 16'h0F0F, 1'b0, 1'b0, "R10 first");
        run_op(16'hFF00, 16'hF0F0, 1'b1, 1'b0, "R10 second");
        run_op(16'h4321, 16'h0001, 1'b0, 1'b0, "R10 third");
        idle_gap(2);

        // Pseudo-random operands in both modes
        for (int i = 0; i < 800; i++) begin
            logic [15:0] ra, rb;
            rng = next_rng(rng);
            ra  = rng[15:0];
            rb  = rng[31:16];
            run_op(ra, rb, i[0], 1'b0, "random");
            if (i % 7 != 0) idle_gap(1);
        end
        idle_gap(2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule